// File: doc/BRIEF.md
# Interrupt Feedback Port

This block is a single byte-wide register on a small processor bus that lets test software pull the processor's own maskable and non-maskable interrupt request lines. A write to the port address stores the byte. Two fixed bit positions are turned into active-low request outputs, and a third bit raises a halt request used to stop a test run. Software on the same processor can therefore trigger an interrupt on itself, check how it is taken, and then release the line again from its handler.

Three build-time choices change how a stored bit maps onto a line:
- **Drive mode.** In open-collector mode a stored 1 pulls the line. In push-pull mode a stored 0 pulls it.
- **Direction register.** An optional second register sits at its own address. When it is present, a line is pulled only where the direction bit is 1 and the port bit is 0.
- **Non-maskable line.** Its mapping can be turned off completely.

All outputs come straight from flip-flops. Reads return the register contents in the same cycle with no wait state.

Top module: `irq_loopback_port`

## Requirements
- R1: After a synchronous reset both request lines are high and `halt_req` is low. The port register reads 0x03 in push-pull mode without a direction register and 0x00 otherwise. The direction register reads 0x00.
- R2: A write with `bus_addr` equal to `PORT_ADDR` (default 0xBFFC) stores all eight data bits. The outputs reflect the new value in the cycle after the write strobe.
- R3: Open-collector mode without a direction register: port bit 0 = 1 drives `irq_n` low and 0 releases it. Port bit 1 controls `nmi_n` the same way.
- R4: Push-pull mode without a direction register: port bit 0 = 0 drives `irq_n` low and 1 releases it. Port bit 1 controls `nmi_n` the same way.
- R5: With the direction register present (written at `DIR_ADDR`, default 0xBFFD), a line is low exactly when its direction bit is 1 and its port bit is 0, whatever the drive mode.
- R6: A single write that asserts both bit 0 and bit 1 lowers `irq_n` and `nmi_n` in the same cycle.
- R7: With `NMI_EN` = 0, `nmi_n` stays high for any register value, and bit 1 is still stored and read back.
- R8: Port bit 7 set raises `halt_req`. Clearing bit 7 (for example with a write already masked by 0x7F) drops it.
- R9: While `bus_rd` is high, a read of `PORT_ADDR` returns the port register. A read of `DIR_ADDR` returns the direction register when it exists and 0x00 when it does not. `bus_rdata` is 0x00 whenever no decoded read is in progress.
- R10: Writes to any other address, and writes to `DIR_ADDR` when there is no direction register, change no register or output. Without a write, the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| irq_n | output | 1 | Maskable interrupt request, active low |
| nmi_n | output | 1 | Non-maskable interrupt request, active low |
| halt_req | output | 1 | Diagnostic stop request, active high |

## Verification
The hardest state to reach is one where the direction-register build pulls both lines at once. That needs a direction write enabling both bits to land while the port bits are already 0, so the two registers must be sequenced in a particular order. The bench gets there by writing the direction register after clearing the port, and later narrows the direction mask to release one line alone. The stimulus runs three builds side by side on one shared bus: direction register present, open-collector, and push-pull with no non-maskable mapping. Each access therefore also shows that builds without a direction register ignore the direction address.

// File: rtl/ifb_pkg.sv
package ifb_pkg;

  localparam int unsigned FB_W = 8;

  // Whether a line is pulled low for one bit position.
  function automatic logic line_low(input logic port_bit, input logic dir_bit,
                                    input bit has_dir, input bit open_drain);
    if (has_dir)         return dir_bit & ~port_bit;
    else if (open_drain) return port_bit;
    else                 return ~port_bit;
  endfunction

  // Reset value of the port register that keeps both lines released.
  function automatic logic [FB_W-1:0] port_reset(input bit has_dir, input bit open_drain,
                                                 input int irq_bit, input int nmi_bit);
    logic [FB_W-1:0] v;
    v = '0;
    if (!has_dir && !open_drain) begin
      v[irq_bit] = 1'b1;
      v[nmi_bit] = 1'b1;
    end
    return v;
  endfunction

endpackage

// File: rtl/ifb_decode.sv
module ifb_decode #(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hBFFC,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 16'hBFFD,
  parameter bit                HAS_DIR   = 1'b1
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic              wr_port,
  output logic              wr_dir,
  output logic              rd_port,
  output logic              rd_dir
);

  logic hit_port;
  logic hit_dir;

  assign hit_port = (bus_addr == PORT_ADDR);

  generate
    if (HAS_DIR) begin : g_dir_hit
      assign hit_dir = (bus_addr == DIR_ADDR);
    end else begin : g_no_dir_hit
      assign hit_dir = 1'b0;
    end
  endgenerate

  assign wr_port = bus_wr & hit_port;
  assign wr_dir  = bus_wr & hit_dir;
  assign rd_port = bus_rd & hit_port;
  assign rd_dir  = bus_rd & hit_dir;

endmodule

// File: rtl/ifb_regs.sv
module ifb_regs
  import ifb_pkg::*;
#(
  parameter bit HAS_DIR    = 1'b1,
  parameter bit OPEN_DRAIN = 1'b1,
  parameter int IRQ_BIT    = 0,
  parameter int NMI_BIT    = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_port,
  input  logic            wr_dir,
  input  logic [FB_W-1:0] wdata,
  output logic [FB_W-1:0] port_q,
  output logic [FB_W-1:0] dir_q,
  output logic [FB_W-1:0] port_nx,
  output logic [FB_W-1:0] dir_nx
);

  localparam logic [FB_W-1:0] PORT_RST = port_reset(HAS_DIR, OPEN_DRAIN, IRQ_BIT, NMI_BIT);

  assign port_nx = wr_port ? wdata : port_q;

  always_ff @(posedge clk) begin
    if (!rst_n) port_q <= PORT_RST;
    else        port_q <= port_nx;
  end

  generate
    if (HAS_DIR) begin : g_dir_reg
      assign dir_nx = wr_dir ? wdata : dir_q;
      always_ff @(posedge clk) begin
        if (!rst_n) dir_q <= '0;
        else        dir_q <= dir_nx;
      end
    end else begin : g_no_dir_reg
      logic unused_dir_wr;
      assign unused_dir_wr = wr_dir;
      assign dir_nx = '0;
      assign dir_q  = '0;
    end
  endgenerate

endmodule

// File: rtl/ifb_drive.sv
module ifb_drive
  import ifb_pkg::*;
#(
  parameter bit HAS_DIR    = 1'b1,
  parameter bit OPEN_DRAIN = 1'b1,
  parameter bit NMI_EN     = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_port,
  input  logic irq_dir,
  input  logic nmi_port,
  input  logic nmi_dir,
  input  logic stop_bit,
  output logic irq_n,
  output logic nmi_n,
  output logic halt_req
);

  logic irq_pull;
  logic nmi_pull;

  assign irq_pull = line_low(irq_port, irq_dir, HAS_DIR, OPEN_DRAIN);
  assign nmi_pull = line_low(nmi_port, nmi_dir, HAS_DIR, OPEN_DRAIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_n    <= 1'b1;
      halt_req <= 1'b0;
    end else begin
      irq_n    <= ~irq_pull;
      halt_req <= stop_bit;
    end
  end

  generate
    if (NMI_EN) begin : g_nmi_line
      always_ff @(posedge clk) begin
        if (!rst_n) nmi_n <= 1'b1;
        else        nmi_n <= ~nmi_pull;
      end
    end else begin : g_nmi_off
      logic unused_nmi;
      assign unused_nmi = nmi_pull;
      assign nmi_n = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/irq_loopback_port.sv
module irq_loopback_port
  import ifb_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR  = 16'hBFFC,
  parameter logic [ADDR_W-1:0] DIR_ADDR   = 16'hBFFD,
  parameter bit                HAS_DIR    = 1'b1,
  parameter bit                OPEN_DRAIN = 1'b1,
  parameter bit                NMI_EN     = 1'b1,
  parameter int                IRQ_BIT    = 0,
  parameter int                NMI_BIT    = 1,
  parameter int                STOP_BIT   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [FB_W-1:0]   bus_wdata,
  output logic [FB_W-1:0]   bus_rdata,
  output logic              irq_n,
  output logic              nmi_n,
  output logic              halt_req
);

  // Named internal events, visible to the bound checker.
  logic            wr_port;
  logic            wr_dir;
  logic            rd_port;
  logic            rd_dir;
  logic [FB_W-1:0] port_q;
  logic [FB_W-1:0] dir_q;
  logic [FB_W-1:0] port_nx;
  logic [FB_W-1:0] dir_nx;

  ifb_decode #(
    .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR), .DIR_ADDR(DIR_ADDR), .HAS_DIR(HAS_DIR)
  ) u_decode (
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .wr_port(wr_port), .wr_dir(wr_dir), .rd_port(rd_port), .rd_dir(rd_dir)
  );

  ifb_regs #(
    .HAS_DIR(HAS_DIR), .OPEN_DRAIN(OPEN_DRAIN), .IRQ_BIT(IRQ_BIT), .NMI_BIT(NMI_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_port(wr_port), .wr_dir(wr_dir), .wdata(bus_wdata),
    .port_q(port_q), .dir_q(dir_q), .port_nx(port_nx), .dir_nx(dir_nx)
  );

  // Outputs are registered from next-state values so they move on the write edge.
  ifb_drive #(
    .HAS_DIR(HAS_DIR), .OPEN_DRAIN(OPEN_DRAIN), .NMI_EN(NMI_EN)
  ) u_drive (
    .clk(clk), .rst_n(rst_n),
    .irq_port(port_nx[IRQ_BIT]), .irq_dir(dir_nx[IRQ_BIT]),
    .nmi_port(port_nx[NMI_BIT]), .nmi_dir(dir_nx[NMI_BIT]),
    .stop_bit(port_nx[STOP_BIT]),
    .irq_n(irq_n), .nmi_n(nmi_n), .halt_req(halt_req)
  );

  always_comb begin
    if (rd_port)     bus_rdata = port_q;
    else if (rd_dir) bus_rdata = dir_q;
    else             bus_rdata = '0;
  end

endmodule

// File: rtl/ifb_checker.sv
module ifb_checker
  import ifb_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR  = 16'hBFFC,
  parameter bit                HAS_DIR    = 1'b1,
  parameter bit                OPEN_DRAIN = 1'b1,
  parameter bit                NMI_EN     = 1'b1,
  parameter int                IRQ_BIT    = 0,
  parameter int                NMI_BIT    = 1,
  parameter int                STOP_BIT   = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [FB_W-1:0]   bus_wdata,
  input logic [FB_W-1:0]   bus_rdata,
  input logic              irq_n,
  input logic              nmi_n,
  input logic              halt_req,
  input logic [FB_W-1:0]   port_q,
  input logic [FB_W-1:0]   dir_q
);

  assert_reset_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_n && nmi_n && !halt_req));

  assert_write_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == PORT_ADDR && !HAS_DIR) |=>
      (irq_n == !line_low($past(bus_wdata[IRQ_BIT]), 1'b0, HAS_DIR, OPEN_DRAIN)));

  assert_dir_gating_R5: assert property (@(posedge clk) disable iff (!rst_n)
    HAS_DIR |-> (irq_n == !(dir_q[IRQ_BIT] && !port_q[IRQ_BIT])));

  assert_both_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == PORT_ADDR && !HAS_DIR && NMI_EN &&
     line_low(bus_wdata[IRQ_BIT], 1'b0, HAS_DIR, OPEN_DRAIN) &&
     line_low(bus_wdata[NMI_BIT], 1'b0, HAS_DIR, OPEN_DRAIN)) |=> (!irq_n && !nmi_n));

  assert_nmi_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !NMI_EN |-> nmi_n);

  assert_halt_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == PORT_ADDR && bus_wdata[STOP_BIT]) |=> halt_req);

  assert_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == PORT_ADDR) |-> (bus_rdata == port_q));

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(irq_n) && $stable(nmi_n) && $stable(halt_req)));

endmodule

bind irq_loopback_port ifb_checker #(
  .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR), .HAS_DIR(HAS_DIR), .OPEN_DRAIN(OPEN_DRAIN),
  .NMI_EN(NMI_EN), .IRQ_BIT(IRQ_BIT), .NMI_BIT(NMI_BIT), .STOP_BIT(STOP_BIT)
) u_ifb_checker (.*);

// File: tb/test_irq_loopback_port.sv
`timescale 1ns/1ps
module test_irq_loopback_port;

  localparam logic [15:0] PADDR = 16'hBFFC;
  localparam logic [15:0] DADDR = 16'hBFFD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;

  logic [7:0] rd_d, rd_o, rd_t;
  logic irq_d, nmi_d, halt_d;
  logic irq_o, nmi_o, halt_o;
  logic irq_t, nmi_t, halt_t;

  always #5 clk = ~clk;

  // Direction-register build (defaults).
  irq_loopback_port i_irq_loopback_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rd_d), .irq_n(irq_d), .nmi_n(nmi_d), .halt_req(halt_d));

  // Open-collector build, no direction register.
  irq_loopback_port #(.HAS_DIR(1'b0), .OPEN_DRAIN(1'b1)) i_oc (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rd_o), .irq_n(irq_o), .nmi_n(nmi_o), .halt_req(halt_o));

  // Push-pull build, no direction register, non-maskable mapping off.
  irq_loopback_port #(.HAS_DIR(1'b0), .OPEN_DRAIN(1'b0), .NMI_EN(1'b0)) i_tp (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rd_t), .irq_n(irq_t), .nmi_n(nmi_t), .halt_req(halt_t));

  typedef struct {
    string      req;
    int         sel;
    logic [7:0] exp;
  } item_t;

  item_t sbq[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;

  // Bench model of register contents.
  logic [7:0] m_pd, m_dd, m_po, m_pt;

  function automatic logic [7:0] lines_d();
    return {5'b0, m_pd[7], ~(m_dd[1] & ~m_pd[1]), ~(m_dd[0] & ~m_pd[0])};
  endfunction
  function automatic logic [7:0] lines_o();
    return {5'b0, m_po[7], ~m_po[1], ~m_po[0]};
  endfunction
  function automatic logic [7:0] lines_t();
    return {5'b0, m_pt[7], 1'b1, m_pt[0]};
  endfunction

  task automatic push(input string req, input int sel, input logic [7:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sbq.push_back(it);
  endtask

  task automatic push_lines(input string req);
    push(req, 0, lines_d());
    push(req, 1, lines_o());
    push(req, 2, lines_t());
  endtask

  task automatic model_reset();
    m_pd = 8'h00; m_dd = 8'h00; m_po = 8'h00; m_pt = 8'h03;
  endtask

  task automatic do_reset(input string req);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    model_reset();
    push_lines(req);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
    if (a == PADDR) begin m_pd = d; m_po = d; m_pt = d; end
    if (a == DADDR) m_dd = d;
    push_lines(req);
  endtask

  task automatic rd(input logic [15:0] a, input string req);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    if (a == PADDR) begin
      push(req, 3, m_pd); push(req, 4, m_po); push(req, 5, m_pt);
    end else if (a == DADDR) begin
      push(req, 3, m_dd); push(req, 4, 8'h00); push(req, 5, 8'h00);
    end else begin
      push(req, 3, 8'h00); push(req, 4, 8'h00); push(req, 5, 8'h00);
    end
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  task automatic idle_check(input int cycles, input string req);
    repeat (cycles) @(posedge clk);
    #1;
    push_lines(req);
    push(req, 3, 8'h00); push(req, 4, 8'h00); push(req, 5, 8'h00);
  endtask

  // Monitor: compares queued expectations a little after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (sbq.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sbq.pop_front();
        case (it.sel)
          0: act = {5'b0, halt_d, nmi_d, irq_d};
          1: act = {5'b0, halt_o, nmi_o, irq_o};
          2: act = {5'b0, halt_t, nmi_t, irq_t};
          3: act = rd_d;
          4: act = rd_o;
          default: act = rd_t;
        endcase
        n_tests++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s view=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset("R1 reset lines");
    rd(PADDR, "R1 reset port value");
    rd(DADDR, "R1 reset dir value");
    wr(PADDR, 8'h01, "R3 R4 irq bit set");
    wr(PADDR, 8'h03, "R6 both bits one write");
    rd(PADDR, "R9 port readback");
    wr(PADDR, 8'h00, "R4 push-pull low on zero");
    wr(DADDR, 8'h03, "R5 dir enables both; R10 ignored without dir");
    rd(DADDR, "R9 dir readback");
    rd(PADDR, "R10 port unchanged by dir write");
    wr(PADDR, 8'h02, "R5 port bit1 releases nmi");
    wr(PADDR, 8'h80, "R8 halt set");
    wr(PADDR, 8'h7C, "R8 halt cleared by filtered write");
    wr(16'h1234, 8'hFF, "R10 other address ignored");
    rd(PADDR, "R10 port unchanged by stray write");
    idle_check(5, "R10 R9 idle hold");
    wr(DADDR, 8'h01, "R5 dir narrows to irq");
    wr(PADDR, 8'hFE, "R7 nmi off in push-pull build");
    rd(PADDR, "R7 R2 bit1 stored");
    wr(PADDR, 8'h00, "R5 R2 port cleared under dir 01");
    wr(PADDR, 8'h83, "R2 R8 mixed write");
    do_reset("R1 mid-run reset");
    rd(PADDR, "R1 port after mid-run reset");
    rd(DADDR, "R1 dir after mid-run reset");
    repeat (3) @(posedge clk);
    @(negedge clk);
    #5;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule